// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block divides a 32 kHz-class timebase into a periodic event and turns that event into an interrupt request. Software chooses the period with a 4-bit rate code. Every period is a power of two of timebase cycles, from 4 up to 16384. A 3-bit chain-mode field sets whether the prescaler runs at all. Only one code value lets it count. Every other value, including the all-zero value present after reset, holds the prescaler at zero.

Each period boundary sets a sticky event flag. An enable bit decides whether that flag also raises the request bit and the interrupt pin. Software talks to the block over a small strobe port. It writes the two control registers and reads the status register. A read of the status register returns the flags and clears them in the same access. A boundary that lands on the very cycle of that read is kept.

Top module: `prate_gen`

## Requirements
- R1: With chain mode 2 and a nonzero rate code, the event repeats with this period in clock cycles: code 1 → 128, 2 → 256, 3 → 4, 4 → 8, 5 → 16, 6 → 32, 7 → 64, 8 → 128, 9 → 256, 10 → 512, 11 → 1024, 12 → 2048, 13 → 4096, 14 → 8192, 15 → 16384. After a write to control A, the event flag and `irq` (with enable set) rise at the clock edge that lies P edges after the write edge, where P is the period.
- R2: Rate code 0 produces no event in any chain mode.
- R3: Any chain-mode value other than 2 (for example 0 after reset, or 6 for halt) stops the prescaler and holds it at zero. No event occurs in those modes. On return to mode 2, the first period is a full period.
- R4: Any write to control A restarts the period count from zero, even when the code is unchanged.
- R5: Status bit 6 is set on every period boundary, whatever the state of the enable bit. Status bit 7 (the request) equals status bit 6 AND the enable bit. `irq` follows the request, including when the enable is set after the flag.
- R6: A read of status (address 2) returns `{request, flag, 6'b0}` in `rdata` one cycle later and clears both flags. A boundary on the same edge as the read sets the flag again.
- R7: Address 0 is control A: rate in bits 3:0 and chain mode in bits 6:4. Bit 7 reads 0. Address 1 is control B: interrupt enable in bit 6, with the other bits reading 0. Writes to address 2 are ignored. Reads of address 3 return 0. Reads of control A or B clear nothing.
- R8: After reset, every field is 0, `irq` is low and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting timebase, and the clock of the register port |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled on a rising edge |
| rd_en | input | 1 | Read strobe, sampled on a rising edge |
| addr | input | 2 | Register address (0 control A, 1 control B, 2 status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid the cycle after `rd_en`, held otherwise |
| irq | output | 1 | Registered periodic interrupt request |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle and that every input is stable around the rising edge. The bench drives one strobe at a time on the falling edge and lowers it before the next access, so both assumptions hold. Random rate codes are drawn only from codes 1 to 9, which keeps each random timing run short. A directed pass still covers every code up to the 16384-cycle period.

// File: rtl/prate_pkg.sv
package prate_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned ADDR_W    = 2;
  localparam int unsigned RATE_W    = 4;
  localparam int unsigned MODE_W    = 3;
  localparam int unsigned SHIFT_W   = 4;
  localparam int unsigned MAX_SHIFT = 14;
  localparam int unsigned CNT_W     = MAX_SHIFT;

  localparam logic [ADDR_W-1:0] ADR_CTLA = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_CTLB = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd2;

  localparam logic [MODE_W-1:0] MODE_RUN = 3'd2;

  // log2 of the period for a rate code; 0 means no event
  function automatic logic [SHIFT_W-1:0] rate_shift(input logic [RATE_W-1:0] code);
    logic [SHIFT_W-1:0] s;
    if (code == '0)
      s = '0;
    else if (code <= 4'd2)
      s = SHIFT_W'(code + 4'd6);
    else
      s = SHIFT_W'(code - 4'd1);
    return s;
  endfunction
endpackage

// File: rtl/prate_regs.sv
module prate_regs
  import prate_pkg::*;
#(
  parameter int unsigned P_DATA_W = DATA_W,
  parameter int unsigned P_ADDR_W = ADDR_W,
  parameter int unsigned P_RATE_W = RATE_W,
  parameter int unsigned P_MODE_W = MODE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en_i,
  input  logic [P_ADDR_W-1:0] addr_i,
  input  logic [P_DATA_W-1:0] wdata_i,
  output logic [P_RATE_W-1:0] rate_o,
  output logic                run_o,
  output logic                restart_o,
  output logic                ien_q_o,
  output logic                ien_d_o,
  output logic [P_DATA_W-1:0] ctla_rd_o,
  output logic [P_DATA_W-1:0] ctlb_rd_o
);
  localparam int unsigned MODE_LSB = P_RATE_W;
  localparam int unsigned IEN_BIT  = 6;

  logic [P_RATE_W-1:0] rate_q;
  logic [P_MODE_W-1:0] mode_q;
  logic                ien_q;
  logic                wr_a, wr_b;
  logic                unused_bits;

  assign wr_a = wr_en_i && (addr_i == ADR_CTLA);
  assign wr_b = wr_en_i && (addr_i == ADR_CTLB);
  assign unused_bits = ^{wdata_i[P_DATA_W-1], wdata_i[IEN_BIT-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
      mode_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      if (wr_a) begin
        rate_q <= wdata_i[P_RATE_W-1:0];
        mode_q <= wdata_i[MODE_LSB +: P_MODE_W];
      end
      if (wr_b)
        ien_q <= wdata_i[IEN_BIT];
    end
  end

  assign rate_o    = rate_q;
  assign run_o     = (mode_q == MODE_RUN);
  assign restart_o = wr_a;
  assign ien_q_o   = ien_q;
  assign ien_d_o   = wr_b ? wdata_i[IEN_BIT] : ien_q;
  assign ctla_rd_o = P_DATA_W'({mode_q, rate_q});
  assign ctlb_rd_o = P_DATA_W'({ien_q, {IEN_BIT{1'b0}}});
endmodule

// File: rtl/prate_prescaler.sv
module prate_prescaler
  import prate_pkg::*;
#(
  parameter int unsigned P_CNT_W   = CNT_W,
  parameter int unsigned P_SHIFT_W = SHIFT_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run_i,
  input  logic                 restart_i,
  input  logic [P_SHIFT_W-1:0] shift_i,
  output logic                 tick_o
);
  logic [P_CNT_W-1:0] cnt_q;
  logic [P_CNT_W-1:0] last;
  logic               active;

  assign last   = ~({P_CNT_W{1'b1}} << shift_i);
  assign active = run_i && (shift_i != '0);

  always_ff @(posedge clk) begin
    if (rst || !active || restart_i)
      cnt_q <= '0;
    else if (cnt_q == last)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = active && !restart_i && (cnt_q == last);

  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
    (shift_i != '0) |-> (cnt_q <= last));

  p_stop_clears_r3: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/prate_status.sv
module prate_status
  import prate_pkg::*;
#(
  parameter int unsigned P_DATA_W = DATA_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic                rd_stat_i,
  input  logic                ien_q_i,
  input  logic                ien_d_i,
  output logic [P_DATA_W-1:0] stat_rd_o,
  output logic                irq_o
);
  logic flag_q, flag_d, irq_q;

  assign flag_d = tick_i | (flag_q & !rd_stat_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & ien_d_i;
    end
  end

  assign stat_rd_o = P_DATA_W'({flag_q & ien_q_i, flag_q, 6'b0});
  assign irq_o     = irq_q;

  p_tick_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> flag_q);

  p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_stat_i && !tick_i) |=> !flag_q);

  p_irq_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ien_q_i);
endmodule

// File: rtl/prate_gen.sv
module prate_gen
  import prate_pkg::*;
#(
  parameter int unsigned P_DATA_W = DATA_W,
  parameter int unsigned P_ADDR_W = ADDR_W,
  parameter int unsigned P_CNT_W  = CNT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [P_ADDR_W-1:0] addr,
  input  logic [P_DATA_W-1:0] wdata,
  output logic [P_DATA_W-1:0] rdata,
  output logic                irq
);
  logic [RATE_W-1:0]   rate;
  logic [SHIFT_W-1:0]  shift;
  logic                run, restart, ien_q, ien_d, tick, rd_stat;
  logic [P_DATA_W-1:0] ctla_rd, ctlb_rd, stat_rd;
  logic [P_DATA_W-1:0] rdata_q;

  prate_regs #(
    .P_DATA_W(P_DATA_W), .P_ADDR_W(P_ADDR_W),
    .P_RATE_W(RATE_W),   .P_MODE_W(MODE_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rate_o(rate), .run_o(run), .restart_o(restart),
    .ien_q_o(ien_q), .ien_d_o(ien_d),
    .ctla_rd_o(ctla_rd), .ctlb_rd_o(ctlb_rd)
  );

  assign shift = rate_shift(rate);

  prate_prescaler #(
    .P_CNT_W(P_CNT_W), .P_SHIFT_W(SHIFT_W)
  ) u_pre (
    .clk(clk), .rst(rst), .run_i(run), .restart_i(restart),
    .shift_i(shift), .tick_o(tick)
  );

  assign rd_stat = rd_en && (addr == ADR_STAT);

  prate_status #(
    .P_DATA_W(P_DATA_W)
  ) u_stat (
    .clk(clk), .rst(rst), .tick_i(tick), .rd_stat_i(rd_stat),
    .ien_q_i(ien_q), .ien_d_i(ien_d), .stat_rd_o(stat_rd), .irq_o(irq)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (rd_en) begin
      case (addr)
        ADR_CTLA: rdata_q <= ctla_rd;
        ADR_CTLB: rdata_q <= ctlb_rd;
        ADR_STAT: rdata_q <= stat_rd;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;

  p_halt_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick);

  p_code0_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (rate == '0) |-> !tick);
endmodule

// File: tb/prate_gen_test.sv
module prate_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prate_gen uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic int period_of(input int code);
    case (code)
      1: return 128;   2: return 256;   3: return 4;     4: return 8;
      5: return 16;    6: return 32;    7: return 64;    8: return 128;
      9: return 256;   10: return 512;  11: return 1024; 12: return 2048;
      13: return 4096; 14: return 8192; 15: return 16384;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  // expects enable set; measures one full period after a control A write
  task automatic run_period(input int code, input string tag);
    logic [7:0] v;
    int p;
    p = period_of(code);
    wr(2'd0, 8'h00);
    rd(2'd2, v);
    wr(2'd0, 8'h20 | 8'(code));
    idle(p - 1);
    check({tag, " before boundary"}, irq, 0);
    idle(1);
    check({tag, " at boundary"}, irq, 1);
    rd(2'd2, v);
    check({tag, " status"}, v, 8'hC0);
    check({tag, " cleared"}, irq, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int unsigned seed_init;
    seed_init = $urandom(32'd4711);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R8 reset state
    check("R8 irq", irq, 0);
    check("R8 rdata", rdata, 0);
    rd(2'd0, v); check("R8 ctlA", v, 0);
    rd(2'd1, v); check("R8 ctlB", v, 0);
    rd(2'd2, v); check("R8 status", v, 0);

    // R7 register map
    wr(2'd1, 8'hFF);
    rd(2'd1, v); check("R7 ctlB readback", v, 8'h40);
    wr(2'd0, 8'hE5);
    rd(2'd0, v); check("R7 ctlA bit7 zero", v, 8'h65);
    rd(2'd2, v);
    wr(2'd2, 8'hFF);
    rd(2'd2, v); check("R7 status write ignored", v, 0);
    check("R7 status write no irq", irq, 0);
    rd(2'd0, v); check("R7 ctlA untouched", v, 8'h65);
    rd(2'd3, v); check("R7 addr3", v, 0);

    // R3 reset-state mode 0 does not count
    wr(2'd0, 8'h03);
    rd(2'd2, v);
    idle(60);
    check("R3 mode0 irq", irq, 0);
    rd(2'd2, v); check("R3 mode0 status", v, 0);

    // R1 every code, directed
    for (int c = 1; c < 16; c++) run_period(c, $sformatf("R1 code %0d", c));

    // R1 random codes
    for (int i = 0; i < 12; i++) begin
      int c;
      c = 1 + int'($urandom % 9);
      run_period(c, $sformatf("R1 random code %0d", c));
    end

    // R2 code 0 in run mode
    wr(2'd0, 8'h20);
    rd(2'd2, v);
    idle(300);
    check("R2 irq", irq, 0);
    rd(2'd2, v); check("R2 status", v, 0);

    // R3 halt mid-period, then resume with full period
    wr(2'd0, 8'h23);
    idle(2);
    wr(2'd0, 8'h63);
    rd(2'd2, v);
    idle(50);
    check("R3 halt irq", irq, 0);
    rd(2'd2, v); check("R3 halt status", v, 0);
    wr(2'd0, 8'h23);
    idle(3); check("R3 resume early", irq, 0);
    idle(1); check("R3 resume full period", irq, 1);

    // R3 and R7: all non-run modes with random rate
    for (int m = 0; m < 8; m++) begin
      logic [3:0] r;
      if (m == 2) continue;
      r = 4'(1 + ($urandom % 15));
      wr(2'd0, {1'b0, 3'(m), r});
      rd(2'd2, v);
      idle(40);
      check($sformatf("R3 mode %0d quiet", m), irq, 0);
      rd(2'd0, v);
      check($sformatf("R7 mode %0d readback", m), v, {1'b0, 3'(m), r});
    end

    // R4 restart on same-code write
    wr(2'd0, 8'h00);
    rd(2'd2, v);
    wr(2'd0, 8'h26);
    idle(20);
    wr(2'd0, 8'h26);
    idle(31); check("R4 restart early", irq, 0);
    idle(1);  check("R4 restart boundary", irq, 1);

    // R5 flag set while disabled, request masked
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    rd(2'd2, v);
    wr(2'd0, 8'h23);
    idle(10);
    check("R5 masked irq", irq, 0);
    wr(2'd0, 8'h63);
    rd(2'd2, v); check("R5 flag without request", v, 8'h40);
    rd(2'd2, v); check("R5 cleared", v, 0);
    wr(2'd0, 8'h23);
    idle(5);
    wr(2'd0, 8'h63);
    check("R5 still masked", irq, 0);
    wr(2'd1, 8'h40);
    check("R5 enable after flag", irq, 1);
    rd(2'd2, v); check("R5 request set", v, 8'hC0);

    // R6 boundary on the read edge is kept
    rd(2'd2, v);
    wr(2'd0, 8'h23);
    idle(4);
    rd(2'd2, v); check("R6 first read", v, 8'hC0);
    idle(2);
    rd(2'd2, v); check("R6 collide read", v, 8'h00);
    check("R6 collide irq", irq, 1);
    rd(2'd2, v); check("R6 kept flag", v, 8'hC0);
    wr(2'd0, 8'h63);
    rd(2'd0, v);
    check("R6 ctlA read no clear", irq, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule